// File: doc/BRIEF.md
# Polynomial Adaptive Linearizer

This block corrects a digitized signal that has passed through a distorting analog path. Each accepted sample enters a delay line. The output is a weighted sum over three banks of taps. The linear bank weights the delayed samples themselves. The quadratic bank weights their squares and the cubic bank weights their cubes. Each bank has its own coefficients and its own length. The two nonlinear banks look only at the newest entries of the delay line.

The block has two modes. In learning mode, a desired sample comes in with every input sample. The block forms the error between the desired value and its own output. It then moves every coefficient along the least-mean-square gradient, scaled by a power-of-two step size. In run mode, the coefficients are frozen and only the corrected sample is produced. A single multiplier is shared over all taps, so one sample takes a fixed number of clock cycles. This count is far below one sample period at audio-band rates. Learning is meant to run after power-up, while a broadband stimulus drives the analog path.

Top module: `poly_lms_comp`

## Requirements
- R1: After reset, `busy`, `out_valid` and `out_sample` are all 0, and every coefficient and delay-line entry is zero. Feeding run-mode samples then gives an output of 0.
- R2: A sample is taken when `in_valid` is 1, `busy` is 0 and `clr` is 0. The sample is shifted into the delay line with index 0 as the newest entry. An `in_valid` raised while `busy` is 1 is ignored entirely.
- R3: The output is floor(S / 2^8) saturated to [-128, 127], where S is the sum of three products. The linear part is c_k·x[n-k] for k below 100. The quadratic part is q_k·floor(x[n-k]^2 / 2^7) for k below 20. The cubic part is u_k·floor(x[n-k]^3 / 2^14) for k below 20. Coefficients are 16-bit two's complement.
- R4: With `train` at 0 when the sample is taken, `out_valid` pulses for exactly one cycle, NTOT+1 clock cycles after the accepting edge (NTOT = 140 by default). No coefficient changes.
- R5: With `train` at 1 when the sample is taken, e = ref − y, where y is the saturated output. Every coefficient then gains floor(e·r / 2^mu), where r is its own regressor from R3, and the result saturates to 16 bits. `out_valid` pulses 2·NTOT+1 cycles after the accepting edge.
- R6: `train`, `mu_shift` and `ref_sample` are captured on the accepting edge. Changes to them while `busy` is 1 affect only later samples.
- R7: `clr` is synchronous. It zeroes all coefficients and the delay line, drops any sample in progress without an `out_valid`, and wins over `in_valid` in the same cycle.
- R8: `busy` is 1 from the cycle after the accepting edge until the cycle in which `out_valid` pulses, and `busy` is 0 while `out_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of coefficients and delay line |
| in_valid | input | 1 | Offers a new sample |
| in_sample | input | XW | Signed input sample |
| ref_sample | input | XW | Signed desired sample, used in learning mode |
| train | input | 1 | 1 = learning mode, 0 = run mode |
| mu_shift | input | MUW | Step size as a right-shift count |
| busy | output | 1 | A sample is being processed |
| out_valid | output | 1 | One-cycle pulse: `out_sample` is new |
| out_sample | output | XW | Signed corrected sample |

## Verification
Several controls can meet on a single clock edge. A clear can coincide with a sample offer, and a new offer, mode flip or step change can arrive while a sample is in flight. The bench raises `clr` and `in_valid` on the same edge. It then judges that `busy` stays low and that the next run-mode output is zero. Separately, it raises `in_valid`, changes `train` and changes `mu_shift` in the middle of a learning pass. It then judges that every later output and latency still matches a reference model that saw none of those changes.

// File: rtl/plc_pkg.sv
package plc_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_FILT = 2'd1,
      PH_FIN  = 2'd2,
      PH_UPD  = 2'd3
   } plc_phase_e;

   typedef enum logic [1:0] {
      BK_LIN = 2'd0,
      BK_SQ  = 2'd1,
      BK_CUB = 2'd2
   } plc_bank_e;
endpackage

// File: rtl/plc_delay_line.sv
module plc_delay_line #(
   parameter int XW    = 8,
   parameter int DEPTH = 100
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clr,
   input  logic                       shift,
   input  logic signed [XW-1:0]       din,
   input  logic [$clog2(DEPTH)-1:0]   rd_idx,
   output logic signed [XW-1:0]       dout
);
   logic signed [XW-1:0] taps [DEPTH];

   if (DEPTH < 2) begin : g_bad_depth
      $fatal(1, "plc_delay_line: DEPTH must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          taps[0] <= '0;
      else if (clr)        taps[0] <= '0;
      else if (shift)      taps[0] <= din;
   end

   for (genvar i = 1; i < DEPTH; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       taps[i] <= '0;
         else if (clr)     taps[i] <= '0;
         else if (shift)   taps[i] <= taps[i-1];
      end
   end

   assign dout = (32'(rd_idx) < DEPTH) ? taps[rd_idx] : '0;

   // R2: without a shift or clear, the newest entry holds
   a_r2_no_shift_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!shift && !clr) |=> $stable(taps[0]));
endmodule

// File: rtl/plc_regressor.sv
module plc_regressor
   import plc_pkg::*;
#(
   parameter int XW      = 8,
   parameter bit HAS_SQ  = 1'b1,
   parameter bit HAS_CUB = 1'b1,
   parameter int RW      = XW + 1
) (
   input  logic signed [XW-1:0] sample,
   input  plc_bank_e            bank,
   output logic signed [RW-1:0] rg
);
   logic signed [RW-1:0] lin_r, sq_r, cu_r;

   if (RW != XW + 1) begin : g_bad_rw
      $fatal(1, "plc_regressor: RW must be XW+1");
   end

   assign lin_r = RW'(sample);

   if (HAS_SQ || HAS_CUB) begin : g_sq
      logic signed [2*XW-1:0] sq_full;
      assign sq_full = $signed({{XW{sample[XW-1]}}, sample} * {{XW{sample[XW-1]}}, sample});
      assign sq_r = HAS_SQ ? RW'(sq_full >>> (XW-1)) : '0;
      if (HAS_CUB) begin : g_cub
         logic signed [3*XW-1:0] cu_full;
         assign cu_full = $signed({{XW{sq_full[2*XW-1]}}, sq_full} *
                                  {{(2*XW){sample[XW-1]}}, sample});
         assign cu_r = RW'(cu_full >>> (2*(XW-1)));
      end else begin : g_no_cub
         assign cu_r = '0;
      end
   end else begin : g_lin_only
      assign sq_r = '0;
      assign cu_r = '0;
   end

   always_comb begin
      unique case (bank)
         BK_SQ:   rg = sq_r;
         BK_CUB:  rg = cu_r;
         default: rg = lin_r;
      endcase
   end
endmodule

// File: rtl/plc_coef_bank.sv
module plc_coef_bank #(
   parameter int CW = 16,
   parameter int N  = 140,
   parameter int PW = 25
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clr,
   input  logic                     we,
   input  logic [$clog2(N)-1:0]     idx,
   input  logic signed [PW-1:0]     delta,
   output logic signed [CW-1:0]     rdata
);
   localparam int SW = PW + 1;

   logic signed [CW-1:0] mem [N];
   logic signed [SW-1:0] sum;
   logic        [SW-CW:0] hi;
   logic signed [CW-1:0] wdata;

   if (PW < CW) begin : g_bad_pw
      $fatal(1, "plc_coef_bank: PW must not be narrower than CW");
   end

   assign rdata = (32'(idx) < N) ? mem[idx] : '0;

   always_comb begin
      sum = $signed({{(SW-CW){rdata[CW-1]}}, rdata}) + $signed({delta[PW-1], delta});
      hi  = sum[SW-1:CW-1];
      if (&hi || ~|hi)  wdata = sum[CW-1:0];
      else if (sum[SW-1]) wdata = {1'b1, {(CW-1){1'b0}}};
      else              wdata = {1'b0, {(CW-1){1'b1}}};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) mem[i] <= '0;
      end else if (clr) begin
         for (int i = 0; i < N; i++) mem[i] <= '0;
      end else if (we && (32'(idx) < N)) begin
         mem[idx] <= wdata;
      end
   end

   // R5: a write moves the addressed word toward the sign of delta, never across
   a_r5_sat_direction: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !clr && !delta[PW-1]) |-> (wdata >= rdata));
endmodule

// File: rtl/poly_lms_comp.sv
module poly_lms_comp
   import plc_pkg::*;
#(
   parameter int XW    = 8,
   parameter int NLIN  = 100,
   parameter int NSQ   = 20,
   parameter int NCUB  = 20,
   parameter int CW    = 16,
   parameter int CFRAC = 8,
   parameter int MUW   = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic                 in_valid,
   input  logic signed [XW-1:0] in_sample,
   input  logic signed [XW-1:0] ref_sample,
   input  logic                 train,
   input  logic [MUW-1:0]       mu_shift,
   output logic                 busy,
   output logic                 out_valid,
   output logic signed [XW-1:0] out_sample
);
   localparam int NTOT = NLIN + NSQ + NCUB;
   localparam int IW   = $clog2(NTOT);
   localparam int DW   = $clog2(NLIN);
   localparam int RW   = XW + 1;
   localparam int EW   = XW + 1;
   localparam int PW   = CW + RW;
   localparam int AW   = PW + IW + 1;

   if (NSQ > NLIN || NCUB > NLIN) begin : g_bad_banks
      $fatal(1, "poly_lms_comp: nonlinear banks may not exceed the linear bank");
   end
   if (CW <= EW) begin : g_bad_cw
      $fatal(1, "poly_lms_comp: CW must exceed XW+1");
   end
   if (CFRAC >= AW - XW) begin : g_bad_frac
      $fatal(1, "poly_lms_comp: CFRAC too large for accumulator");
   end

   plc_phase_e            phase;
   logic [IW-1:0]         idx;
   logic                  train_q;
   logic [MUW-1:0]        mu_q;
   logic signed [XW-1:0]  ref_q;
   logic signed [AW-1:0]  acc;
   logic signed [EW-1:0]  err_q;

   plc_bank_e             bank;
   logic [DW-1:0]         tap;
   logic signed [XW-1:0]  xk;
   logic signed [RW-1:0]  rg;
   logic signed [CW-1:0]  coef_rd;
   logic signed [CW-1:0]  op_a;
   logic signed [PW-1:0]  prod;
   logic signed [PW-1:0]  delta;
   logic signed [AW-1:0]  scaled;
   logic        [AW-XW:0] hi;
   logic signed [XW-1:0]  y_sat;
   logic signed [EW-1:0]  err;
   logic                  accept;
   logic                  coef_we;

   assign accept  = in_valid && (phase == PH_IDLE) && !clr;
   assign coef_we = (phase == PH_UPD) && !clr;
   assign busy    = (phase != PH_IDLE);

   // map flat tap index onto bank and delay-line position
   always_comb begin
      if (32'(idx) < NLIN) begin
         bank = BK_LIN;
         tap  = DW'(idx);
      end else if (32'(idx) < NLIN + NSQ) begin
         bank = BK_SQ;
         tap  = DW'(idx - IW'(NLIN));
      end else begin
         bank = BK_CUB;
         tap  = DW'(idx - IW'(NLIN + NSQ));
      end
   end

   plc_delay_line #(.XW(XW), .DEPTH(NLIN)) u_dline (
      .clk(clk), .rst_n(rst_n), .clr(clr), .shift(accept),
      .din(in_sample), .rd_idx(tap), .dout(xk)
   );

   plc_regressor #(.XW(XW), .HAS_SQ(NSQ > 0), .HAS_CUB(NCUB > 0), .RW(RW)) u_regr (
      .sample(xk), .bank(bank), .rg(rg)
   );

   plc_coef_bank #(.CW(CW), .N(NTOT), .PW(PW)) u_coef (
      .clk(clk), .rst_n(rst_n), .clr(clr), .we(coef_we),
      .idx(idx), .delta(delta), .rdata(coef_rd)
   );

   // one shared multiplier: coefficient in filter phase, error in update phase
   always_comb begin
      op_a  = (phase == PH_UPD) ? $signed({{(CW-EW){err_q[EW-1]}}, err_q}) : coef_rd;
      prod  = $signed({{RW{op_a[CW-1]}}, op_a}) * $signed({{CW{rg[RW-1]}}, rg});
      delta = prod >>> mu_q;
   end

   always_comb begin
      scaled = acc >>> CFRAC;
      hi     = scaled[AW-1:XW-1];
      if (&hi || ~|hi)       y_sat = scaled[XW-1:0];
      else if (scaled[AW-1]) y_sat = {1'b1, {(XW-1){1'b0}}};
      else                   y_sat = {1'b0, {(XW-1){1'b1}}};
      err = $signed({ref_q[XW-1], ref_q}) - $signed({y_sat[XW-1], y_sat});
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase      <= PH_IDLE;
         idx        <= '0;
         train_q    <= 1'b0;
         mu_q       <= '0;
         ref_q      <= '0;
         acc        <= '0;
         err_q      <= '0;
         out_valid  <= 1'b0;
         out_sample <= '0;
      end else if (clr) begin
         phase     <= PH_IDLE;
         idx       <= '0;
         acc       <= '0;
         out_valid <= 1'b0;
      end else begin
         out_valid <= 1'b0;
         unique case (phase)
            PH_IDLE: if (in_valid) begin
               phase   <= PH_FILT;
               idx     <= '0;
               acc     <= '0;
               train_q <= train;
               mu_q    <= mu_shift;
               ref_q   <= ref_sample;
            end
            PH_FILT: begin
               acc <= acc + $signed({{(AW-PW){prod[PW-1]}}, prod});
               if (idx == IW'(NTOT-1)) phase <= PH_FIN;
               else                    idx   <= idx + IW'(1);
            end
            PH_FIN: begin
               out_sample <= y_sat;
               err_q      <= err;
               idx        <= '0;
               if (train_q) phase <= PH_UPD;
               else begin
                  phase     <= PH_IDLE;
                  out_valid <= 1'b1;
               end
            end
            PH_UPD: begin
               if (idx == IW'(NTOT-1)) begin
                  phase     <= PH_IDLE;
                  out_valid <= 1'b1;
               end else begin
                  idx <= idx + IW'(1);
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   // R8: result pulses only once processing has finished
   a_r8_idle_on_done: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !busy);
   // R4: the completion pulse lasts one cycle
   a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);
   // R4: coefficients are only written during a learning pass
   a_r4_frozen_coefs: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_UPD) |-> train_q);
   // R6: captured mode and step stay put while a sample is in flight
   a_r6_mode_latched: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(train_q) && $stable(mu_q)));
   // R2: an offer while busy leaves the captured desired sample untouched
   a_r2_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && in_valid) |=> $stable(ref_q));
   // R7: clear returns the block to idle with no pulse
   a_r7_clear_stops: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (!busy && !out_valid));
endmodule

// File: tb/poly_lms_comp_tb.sv
module poly_lms_comp_tb;
   localparam int XW = 8, NLIN = 100, NSQ = 20, NCUB = 20, CW = 16, CFRAC = 8, MUW = 4;
   localparam int NTOT = NLIN + NSQ + NCUB;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic rst_n, clr, in_valid, train, busy, out_valid;
   logic signed [XW-1:0] in_sample, ref_sample, out_sample;
   logic [MUW-1:0] mu_shift;

   poly_lms_comp #(.XW(XW), .NLIN(NLIN), .NSQ(NSQ), .NCUB(NCUB),
                   .CW(CW), .CFRAC(CFRAC), .MUW(MUW)) u_dut (
      .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid),
      .in_sample(in_sample), .ref_sample(ref_sample), .train(train),
      .mu_shift(mu_shift), .busy(busy), .out_valid(out_valid), .out_sample(out_sample)
   );

   typedef struct { int y; int lat; longint t0; } item_t;
   item_t exp_q[$];
   string tag_q[$];

   int n_chk = 0, n_err = 0;
   longint cyc = 0;
   int hist [NLIN];
   int cf [NTOT];
   int lfsr = 16'hACE1;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input longint act, input longint expv);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   function automatic int sat(input longint v, input int lo, input int hi);
      if (v > hi) return hi;
      if (v < lo) return lo;
      return int'(v);
   endfunction

   function automatic int regr(input int k);
      int h;
      if (k < NLIN) return hist[k];
      if (k < NLIN + NSQ) begin h = hist[k-NLIN]; return (h*h) >>> 7; end
      h = hist[k-NLIN-NSQ];
      return (h*h*h) >>> 14;
   endfunction

   function automatic void model_clear();
      for (int i = 0; i < NLIN; i++) hist[i] = 0;
      for (int i = 0; i < NTOT; i++) cf[i] = 0;
   endfunction

   function automatic int model_step(input int x, input int r, input bit tr, input int mu);
      longint acc = 0;
      int y, e;
      for (int i = NLIN-1; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = x;
      for (int k = 0; k < NTOT; k++) acc += longint'(cf[k]) * regr(k);
      y = sat(acc >>> CFRAC, -128, 127);
      if (tr) begin
         e = r - y;
         for (int k = 0; k < NTOT; k++)
            cf[k] = sat(longint'(cf[k]) + ((longint'(e) * regr(k)) >>> mu), -32768, 32767);
      end
      return y;
   endfunction

   function automatic int next_rand();
      lfsr = ((lfsr << 1) | (((lfsr >> 15) ^ (lfsr >> 13) ^ (lfsr >> 12) ^ (lfsr >> 10)) & 1)) & 16'hFFFF;
      return (lfsr % 121) - 60;
   endfunction

   // driver: offer one sample, then push the modelled result
   task automatic send(input int x, input int r, input bit tr, input int mu, input string tag);
      item_t it;
      @(negedge clk);
      while (busy) @(negedge clk);
      in_sample = 8'(x); ref_sample = 8'(r); train = tr; mu_shift = 4'(mu); in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      it.t0  = cyc;
      it.lat = tr ? 2*NTOT + 1 : NTOT + 1;
      it.y   = model_step(x, r, tr, mu);
      exp_q.push_back(it);
      tag_q.push_back(tag);
   endtask

   task automatic drain();
      while (exp_q.size() > 0) @(negedge clk);
      @(negedge clk);
   endtask

   // monitor: compare each completion with the scoreboard head
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R7 unexpected out_valid", 1, 0);
         end else begin
            item_t it;
            string tg;
            it = exp_q.pop_front();
            tg = tag_q.pop_front();
            check(int'(out_sample) == it.y, tg, int'(out_sample), it.y);
            check((cyc - it.t0) == it.lat, {tg, " latency"}, cyc - it.t0, it.lat);
            check(!busy, "R8 busy low at pulse", busy, 0);
         end
      end
   end

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      check(1'b0, "watchdog expired", 0, 1);
      summary();
      $finish;
   end

   initial begin
      int prev;
      model_clear();
      rst_n = 1'b0; clr = 1'b0; in_valid = 1'b0; train = 1'b0;
      in_sample = '0; ref_sample = '0; mu_shift = '0;
      repeat (5) @(negedge clk);
      check(busy == 1'b0, "R1 busy after reset", busy, 0);
      check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
      check(out_sample == 0, "R1 out_sample after reset", out_sample, 0);
      rst_n = 1'b1;

      // R1/R3: zero coefficients give zero output in run mode
      send(50, 0, 1'b0, 0, "R1 zero coefficients");
      send(-77, 0, 1'b0, 0, "R3 zero coefficients");
      send(127, 0, 1'b0, 0, "R4 run mode");
      drain();

      // R5: learning passes; desired = previous input plus a bias
      prev = 0;
      for (int n = 0; n < 30; n++) begin
         int x;
         x = next_rand();
         send(x, prev + 10, 1'b1, 7, "R5 learning");
         prev = x;
         if (n == 2) begin
            // R2/R6: offers, mode flip and step change while busy
            repeat (3) @(negedge clk);
            check(busy == 1'b1, "R8 busy during pass", busy, 1);
            in_valid = 1'b1; in_sample = 8'sd77; ref_sample = -8'sd99;
            train = 1'b0; mu_shift = 4'd0;
            repeat (4) @(negedge clk);
            in_valid = 1'b0;
         end
      end
      drain();

      // R4: frozen coefficients in run mode
      for (int n = 0; n < 10; n++) send(next_rand(), 0, 1'b0, 0, "R4 run frozen");
      send(33, 0, 1'b0, 0, "R4 run frozen");
      send(33, 0, 1'b0, 0, "R4 run frozen");
      drain();

      // R3/R5: drive coefficients and output into saturation
      for (int n = 0; n < 6; n++) send(127, 127, 1'b1, 0, "R5 coef saturation");
      send(127, 0, 1'b0, 0, "R3 output saturation high");
      send(-128, 0, 1'b0, 0, "R3 cubic and square banks");
      for (int n = 0; n < 4; n++) send(-128, -128, 1'b1, 0, "R5 coef saturation negative");
      send(-128, 0, 1'b0, 0, "R3 output saturation");
      drain();

      // R7: clear and offer on the same edge
      @(negedge clk);
      clr = 1'b1; in_valid = 1'b1; in_sample = 8'sd50; train = 1'b0;
      @(negedge clk);
      clr = 1'b0; in_valid = 1'b0;
      check(busy == 1'b0, "R7 clear beats offer", busy, 0);
      model_clear();
      send(90, 0, 1'b0, 0, "R7 cleared output");
      drain();

      // R7: clear abandons a pass in flight
      for (int n = 0; n < 5; n++) send(next_rand(), 40, 1'b1, 5, "R5 learning");
      drain();
      @(negedge clk);
      in_valid = 1'b1; in_sample = 8'sd20; train = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      repeat (20) @(negedge clk);
      check(busy == 1'b1, "R8 busy mid pass", busy, 1);
      clr = 1'b1;
      @(negedge clk);
      clr = 1'b0;
      check(busy == 1'b0, "R7 clear drops pass", busy, 0);
      model_clear();
      repeat (2*NTOT + 10) @(negedge clk);
      send(-100, 0, 1'b0, 0, "R7 cleared after abort");
      drain();

      check(exp_q.size() == 0, "R4 all results seen", exp_q.size(), 0);
      summary();
      $finish;
   end
endmodule